// File: doc/BRIEF.md
# UART Register Bank Front End

This block is the register side of a classic 16550-style serial port. A simple bus master issues single 16-bit reads and writes, and each request gets a registered response one clock later. The registers sit on a four-byte stride. Bit 7 of the line-control register decides what the two lowest slots reach. When it is set they reach the two baud divisor halves. When it is clear they reach the data register and the interrupt-enable register.

Writing the data register sends the low byte out through a byte port with a one-cycle strobe. Received bytes come in through a byte port qualified by a valid level. The block does not generate baud rates or serialise frames. When the modem-control loopback bit is set, one transmitted byte is held internally and returned by the next data read, and the external receive port is not used. The line-status register reports stored status bits merged with live readiness, and it clears its stored part whenever it is read. Requests of the wrong width and requests to unmapped slots get an error code and change nothing.

Top module: `uart_reg_bank`

## Requirements
- R1: After reset, the register values are as follows. Reads with the divisor bit set give DLL 0x0001 and DLH 0x0000. IIR (0x08) reads 0x0001. The first LSR read (0x14) gives 0x0060 when there is no live status. The data register, IER, LCR, MCR, scratch and global control all read 0x0000.
- R2: The divisor bit is LCR bit 7. When it is 1, offset 0x00 reads and writes DLL and offset 0x04 reads and writes DLH. When it is 0, offset 0x00 is data and offset 0x04 is IER. A divisor write does not pulse txStrobe.
- R3: LCR (0x0C), MCR (0x10), scratch (0x1C) and global control (0x24) store and return all 16 written bits.
- R4: Writes to IIR (0x08) and LSR (0x14) complete with code 0 but change nothing that a later read returns.
- R5: An LSR read returns the stored bits ORed with live status. Bit 0 is data-ready. Bits 5 and 6 follow txIdle. After the read the stored bits are zero.
- R6: Loopback is MCR bit 4. With loopback on, a THR write holds its low byte and sets data-ready. The next data read returns that byte and clears the hold. While loopback is on, rxValid/rxData are ignored.
- R7: A data read with no held byte returns {8'h00, rxData} when rxValid is 1 and loopback is off. Otherwise it returns the previous data-register value.
- R8: A THR write pulses txStrobe for one cycle with txData equal to the low byte, in the response cycle. txEvent pulses in the same cycle only if IER bit 1 is set.
- R9: rxEvent is high exactly while IER bit 0 is set and data-ready is true.
- R10: A request whose busSize is not 1 (size code = log2 of bytes, 1 = 16-bit) responds with respCode 1 and changes no state. This holds even when the offset is also unmapped.
- R11: A 16-bit request to an unmapped or misaligned offset (0x18, 0x20, above 0x24, low two address bits non-zero) responds with respCode 2 and changes no state.
- R12: Each request raises respValid exactly in the following cycle. respData is zero for writes and errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Request present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Access size code, log2 of bytes |
| busAddr | input | 8 | Byte offset into the bank |
| busWdata | input | 16 | Write data |
| respValid | output | 1 | Response for the previous cycle's request |
| respCode | output | 2 | 0 ok, 1 wrong width, 2 unmapped offset |
| respData | output | 16 | Read data |
| txData | output | 8 | Transmitted byte |
| txStrobe | output | 1 | One-cycle pulse per THR write |
| txEvent | output | 1 | Transmit interrupt event pulse |
| txIdle | input | 1 | Transmitter empty, drives LSR bits 5 and 6 |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | rxData holds a byte |
| rxEvent | output | 1 | Receive interrupt event level |

## Verification
The bench uses the default parameters: an 8-bit address, 16-bit data and a four-byte stride. With these, the holes at 0x18 and 0x20, the offsets past the last slot and misaligned offsets can all be reached in one address byte. Because the size code is two bits wide, both a narrower and a wider access can be driven, and each can be combined with an unmapped offset to show that the width error takes priority. With 8-bit bytes inside 16-bit registers, the bench can show that transmit and loopback keep only the low byte, while the storage registers keep all sixteen bits.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

  typedef enum logic [1:0] {
    RESP_OK    = 2'd0,
    RESP_WIDTH = 2'd1,
    RESP_ADDR  = 2'd2
  } respCodeT;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DLL,
    SEL_IER,
    SEL_DLH,
    SEL_IIR,
    SEL_LCR,
    SEL_MCR,
    SEL_LSR,
    SEL_SCR,
    SEL_GCTL
  } regSelT;

  typedef struct packed {
    logic     respNow;
    respCodeT code;
    regSelT   rdSel;
    logic     rdData;
    logic     rdLsr;
    logic     wrThr;
    logic     wrDll;
    logic     wrDlh;
    logic     wrIer;
    logic     wrLcr;
    logic     wrMcr;
    logic     wrScr;
    logic     wrGctl;
  } ctrlStrobeT;

endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STRIDE_LG = 2,
  parameter int SIZE_W    = 2,
  parameter int HALF_SIZE = 1
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [SIZE_W-1:0] busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              dlabOn,
  output ctrlStrobeT        strb
);

  localparam int SLOT_W = ADDR_W - STRIDE_LG;
  localparam logic [SLOT_W-1:0] SLOT_DATA = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] SLOT_IER  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_IIR  = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] SLOT_LCR  = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] SLOT_MCR  = SLOT_W'(4);
  localparam logic [SLOT_W-1:0] SLOT_LSR  = SLOT_W'(5);
  localparam logic [SLOT_W-1:0] SLOT_SCR  = SLOT_W'(7);
  localparam logic [SLOT_W-1:0] SLOT_GCTL = SLOT_W'(9);
  localparam logic [SIZE_W-1:0] SIZE_OK   = SIZE_W'(HALF_SIZE);

  logic [SLOT_W-1:0] slotIdx;
  logic              aligned;
  regSelT            sel;

  assign slotIdx = busAddr[ADDR_W-1:STRIDE_LG];
  assign aligned = (busAddr[STRIDE_LG-1:0] == '0);

  // slot decode; the divisor bit banks the two lowest slots
  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      case (slotIdx)
        SLOT_DATA: sel = dlabOn ? SEL_DLL : SEL_DATA;
        SLOT_IER:  sel = dlabOn ? SEL_DLH : SEL_IER;
        SLOT_IIR:  sel = SEL_IIR;
        SLOT_LCR:  sel = SEL_LCR;
        SLOT_MCR:  sel = SEL_MCR;
        SLOT_LSR:  sel = SEL_LSR;
        SLOT_SCR:  sel = SEL_SCR;
        SLOT_GCTL: sel = SEL_GCTL;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  // width check outranks the missing-register check
  always_comb begin
    strb       = '0;
    strb.code  = RESP_OK;
    strb.rdSel = SEL_NONE;
    if (busValid) begin
      strb.respNow = 1'b1;
      if (busSize != SIZE_OK) begin
        strb.code = RESP_WIDTH;
      end else if (sel == SEL_NONE) begin
        strb.code = RESP_ADDR;
      end else if (busWrite) begin
        case (sel)
          SEL_DATA: strb.wrThr  = 1'b1;
          SEL_DLL:  strb.wrDll  = 1'b1;
          SEL_DLH:  strb.wrDlh  = 1'b1;
          SEL_IER:  strb.wrIer  = 1'b1;
          SEL_LCR:  strb.wrLcr  = 1'b1;
          SEL_MCR:  strb.wrMcr  = 1'b1;
          SEL_SCR:  strb.wrScr  = 1'b1;
          SEL_GCTL: strb.wrGctl = 1'b1;
          default:  ;
        endcase
      end else begin
        strb.rdSel  = sel;
        strb.rdData = (sel == SEL_DATA);
        strb.rdLsr  = (sel == SEL_LSR);
      end
    end
  end

endmodule

// File: rtl/uart_reg_dp.sv
module uart_reg_dp
  import uart_reg_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int DLAB_BIT  = 7,
  parameter int LOOP_BIT  = 4,
  parameter int ERBFI_BIT = 0,
  parameter int ETBEI_BIT = 1,
  parameter int DR_BIT    = 0,
  parameter int THRE_BIT  = 5,
  parameter int TEMT_BIT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              txIdle,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  output logic              dlabOn,
  output logic              respValid,
  output logic [1:0]        respCode,
  output logic [DATA_W-1:0] respData,
  output logic [BYTE_W-1:0] txData,
  output logic              txStrobe,
  output logic              txEvent,
  output logic              rxEvent
);

  localparam logic [DATA_W-1:0] DLL_RST = DATA_W'(1);
  localparam logic [DATA_W-1:0] IIR_RST = DATA_W'(1);
  localparam logic [DATA_W-1:0] LSR_RST =
    DATA_W'((1 << THRE_BIT) | (1 << TEMT_BIT));

  logic [DATA_W-1:0] dllReg, dlhReg, ierReg, lcrReg, mcrReg, scrReg, gctlReg;
  logic [DATA_W-1:0] rbrReg, lsrStore;
  logic [BYTE_W-1:0] loopByte;
  logic              loopPend;
  logic              loopOn;
  logic              dataReady;
  logic [DATA_W-1:0] liveStat;
  logic [DATA_W-1:0] dataNext;
  logic [DATA_W-1:0] rdMux;

  assign dlabOn    = lcrReg[DLAB_BIT];
  assign loopOn    = mcrReg[LOOP_BIT];
  assign dataReady = loopPend | (~loopOn & rxValid);
  assign rxEvent   = ierReg[ERBFI_BIT] & dataReady;

  always_comb begin
    liveStat           = '0;
    liveStat[DR_BIT]   = dataReady;
    liveStat[THRE_BIT] = txIdle;
    liveStat[TEMT_BIT] = txIdle;
  end

  // value a data read would return this cycle
  always_comb begin
    if (loopPend)
      dataNext = DATA_W'(loopByte);
    else if (!loopOn && rxValid)
      dataNext = DATA_W'(rxData);
    else
      dataNext = rbrReg;
  end

  always_comb begin
    case (strb.rdSel)
      SEL_DATA: rdMux = dataNext;
      SEL_DLL:  rdMux = dllReg;
      SEL_DLH:  rdMux = dlhReg;
      SEL_IER:  rdMux = ierReg;
      SEL_IIR:  rdMux = IIR_RST;
      SEL_LCR:  rdMux = lcrReg;
      SEL_MCR:  rdMux = mcrReg;
      SEL_LSR:  rdMux = lsrStore | liveStat;
      SEL_SCR:  rdMux = scrReg;
      SEL_GCTL: rdMux = gctlReg;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dllReg    <= DLL_RST;
      dlhReg    <= '0;
      ierReg    <= '0;
      lcrReg    <= '0;
      mcrReg    <= '0;
      scrReg    <= '0;
      gctlReg   <= '0;
      rbrReg    <= '0;
      lsrStore  <= LSR_RST;
      loopByte  <= '0;
      loopPend  <= 1'b0;
      respValid <= 1'b0;
      respCode  <= RESP_OK;
      respData  <= '0;
      txData    <= '0;
      txStrobe  <= 1'b0;
      txEvent   <= 1'b0;
    end else begin
      respValid <= strb.respNow;
      respCode  <= strb.code;
      respData  <= rdMux;
      txStrobe  <= 1'b0;
      txEvent   <= 1'b0;
      if (strb.wrDll)  dllReg  <= busWdata;
      if (strb.wrDlh)  dlhReg  <= busWdata;
      if (strb.wrIer)  ierReg  <= busWdata;
      if (strb.wrLcr)  lcrReg  <= busWdata;
      if (strb.wrMcr)  mcrReg  <= busWdata;
      if (strb.wrScr)  scrReg  <= busWdata;
      if (strb.wrGctl) gctlReg <= busWdata;
      if (strb.wrThr) begin
        txData   <= busWdata[BYTE_W-1:0];
        txStrobe <= 1'b1;
        txEvent  <= ierReg[ETBEI_BIT];
        if (loopOn) begin
          loopByte <= busWdata[BYTE_W-1:0];
          loopPend <= 1'b1;
        end
      end
      if (strb.rdData) begin
        rbrReg <= dataNext;
        if (loopPend) loopPend <= 1'b0;
      end
      if (strb.rdLsr) lsrStore <= '0;
    end
  end

  AST_TX_EVENT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    txEvent |-> txStrobe); // R8

  AST_LSR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLsr |=> (lsrStore == '0)); // R5

  AST_LOOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrThr && loopOn) |=> loopPend); // R6

  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respCode != RESP_OK) |->
      (lcrReg == $past(lcrReg) && scrReg == $past(scrReg) &&
       ierReg == $past(ierReg) && !txStrobe)); // R10

endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int STRIDE_LG = 2,
  parameter int SIZE_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [SIZE_W-1:0] busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              respValid,
  output logic [1:0]        respCode,
  output logic [DATA_W-1:0] respData,
  output logic [BYTE_W-1:0] txData,
  output logic              txStrobe,
  output logic              txEvent,
  input  logic              txIdle,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxEvent
);

  localparam int HALF_SIZE = $clog2(DATA_W / 8);

  ctrlStrobeT strb;
  logic       dlabOn;

  uart_reg_ctrl #(
    .ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG), .SIZE_W(SIZE_W), .HALF_SIZE(HALF_SIZE)
  ) ctrl_i (
    .busValid(busValid), .busWrite(busWrite), .busSize(busSize),
    .busAddr(busAddr), .dlabOn(dlabOn), .strb(strb)
  );

  uart_reg_dp #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .txIdle(txIdle), .rxData(rxData), .rxValid(rxValid), .dlabOn(dlabOn),
    .respValid(respValid), .respCode(respCode), .respData(respData),
    .txData(txData), .txStrobe(txStrobe), .txEvent(txEvent), .rxEvent(rxEvent)
  );

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> respValid); // R12

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !respValid); // R12

endmodule

// File: tb/uart_reg_bank_tb.sv
`timescale 1ns/1ps
module uart_reg_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busSize = 2'd1;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        respValid;
  logic [1:0]  respCode;
  logic [15:0] respData;
  logic [7:0]  txData;
  logic        txStrobe;
  logic        txEvent;
  logic        txIdle = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxValid = 1'b0;
  logic        rxEvent;

  int errors = 0;
  int checks = 0;
  logic [15:0] rd;
  logic [1:0]  code;
  logic        sawStrobe, sawEvent, sawValid;
  logic [7:0]  sawTx;

  always #4 clk = ~clk;

  uart_reg_bank dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata),
    .respValid(respValid), .respCode(respCode), .respData(respData),
    .txData(txData), .txStrobe(txStrobe), .txEvent(txEvent), .txIdle(txIdle),
    .rxData(rxData), .rxValid(rxValid), .rxEvent(rxEvent)
  );

  task automatic checkEq(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] addr, input logic [1:0] sz,
                        input logic [15:0] wd);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busSize = sz; busWdata = wd;
    @(posedge clk);
    @(negedge clk);
    rd = respData; code = respCode; sawValid = respValid;
    sawStrobe = txStrobe; sawEvent = txEvent; sawTx = txData;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wr16(input logic [7:0] addr, input logic [15:0] wd);
    access(1'b1, addr, 2'd1, wd);
  endtask

  task automatic rd16(input logic [7:0] addr);
    access(1'b0, addr, 2'd1, 16'h0);
  endtask

  task automatic testReset;
    rd16(8'h00); checkEq("R1 data", rd, 16'h0000);
    checkEq("R12 respValid", {15'h0, sawValid}, 16'h0001);
    rd16(8'h04); checkEq("R1 IER", rd, 16'h0000);
    rd16(8'h08); checkEq("R1 IIR", rd, 16'h0001);
    rd16(8'h0C); checkEq("R1 LCR", rd, 16'h0000);
    rd16(8'h10); checkEq("R1 MCR", rd, 16'h0000);
    rd16(8'h1C); checkEq("R1 SCR", rd, 16'h0000);
    rd16(8'h24); checkEq("R1 GCTL", rd, 16'h0000);
    rd16(8'h14); checkEq("R1 LSR first read", rd, 16'h0060);
    rd16(8'h14); checkEq("R5 LSR cleared after read", rd, 16'h0000);
    wr16(8'h0C, 16'h0080);
    checkEq("R12 write data zero", rd, 16'h0000);
    rd16(8'h00); checkEq("R1 DLL", rd, 16'h0001);
    rd16(8'h04); checkEq("R1 DLH", rd, 16'h0000);
    wr16(8'h0C, 16'h0000);
  endtask

  task automatic testDivisorBank;
    wr16(8'h0C, 16'h0080);
    wr16(8'h00, 16'h1234);
    checkEq("R2 divisor write no strobe", {15'h0, sawStrobe}, 16'h0000);
    wr16(8'h04, 16'h00AB);
    rd16(8'h00); checkEq("R2 DLL", rd, 16'h1234);
    rd16(8'h04); checkEq("R2 DLH", rd, 16'h00AB);
    wr16(8'h0C, 16'h0003);
    rd16(8'h04); checkEq("R2 IER visible", rd, 16'h0000);
    rd16(8'h00); checkEq("R2 data visible", rd, 16'h0000);
    wr16(8'h0C, 16'h0080);
    rd16(8'h00); checkEq("R2 DLL kept", rd, 16'h1234);
    wr16(8'h0C, 16'h0000);
  endtask

  task automatic testStorage;
    wr16(8'h0C, 16'h5A03); rd16(8'h0C); checkEq("R3 LCR", rd, 16'h5A03);
    wr16(8'h10, 16'h0F0F); rd16(8'h10); checkEq("R3 MCR", rd, 16'h0F0F);
    wr16(8'h1C, 16'hBEEF); rd16(8'h1C); checkEq("R3 SCR", rd, 16'hBEEF);
    wr16(8'h24, 16'hA5C3); rd16(8'h24); checkEq("R3 GCTL", rd, 16'hA5C3);
    wr16(8'h10, 16'h0000);
    wr16(8'h0C, 16'h0000);
  endtask

  task automatic testIgnored;
    wr16(8'h08, 16'hFFFF); checkEq("R4 IIR write code", {14'h0, code}, 16'h0000);
    rd16(8'h08); checkEq("R4 IIR unchanged", rd, 16'h0001);
    wr16(8'h14, 16'hFFFF); checkEq("R4 LSR write code", {14'h0, code}, 16'h0000);
    rd16(8'h14); checkEq("R4 LSR unchanged", rd, 16'h0000);
  endtask

  task automatic testLiveStatus;
    txIdle = 1'b1;
    rd16(8'h14); checkEq("R5 LSR tx idle", rd, 16'h0060);
    rxValid = 1'b1; rxData = 8'h11;
    rd16(8'h14); checkEq("R5 LSR idle and ready", rd, 16'h0061);
    txIdle = 1'b0;
    rd16(8'h14); checkEq("R5 LSR ready only", rd, 16'h0001);
    rxValid = 1'b0;
  endtask

  task automatic testReceive;
    rxValid = 1'b1; rxData = 8'h3C;
    rd16(8'h00); checkEq("R7 rx byte", rd, 16'h003C);
    rxValid = 1'b0; rxData = 8'hEE;
    rd16(8'h00); checkEq("R7 previous value", rd, 16'h003C);
    rxValid = 1'b1; rxData = 8'h77;
    rd16(8'h00); checkEq("R7 next byte", rd, 16'h0077);
    rxValid = 1'b0;
  endtask

  task automatic testLoopback;
    wr16(8'h10, 16'h0010);
    rxValid = 1'b1; rxData = 8'h99;
    rd16(8'h14); checkEq("R6 rx ignored in loopback", rd, 16'h0000);
    wr16(8'h00, 16'h12C5);
    checkEq("R8 strobe", {15'h0, sawStrobe}, 16'h0001);
    checkEq("R8 tx byte", {8'h0, sawTx}, 16'h00C5);
    rd16(8'h14); checkEq("R6 held byte ready", rd, 16'h0001);
    rd16(8'h00); checkEq("R6 held byte read", rd, 16'h00C5);
    rd16(8'h00); checkEq("R6 hold consumed", rd, 16'h00C5);
    rd16(8'h14); checkEq("R6 ready cleared", rd, 16'h0000);
    wr16(8'h10, 16'h0000);
    rd16(8'h00); checkEq("R7 rx after loopback", rd, 16'h0099);
    rxValid = 1'b0;
  endtask

  task automatic testEvents;
    wr16(8'h04, 16'h0002);
    wr16(8'h00, 16'h0041);
    checkEq("R8 txEvent with enable", {15'h0, sawEvent}, 16'h0001);
    checkEq("R8 tx byte 0x41", {8'h0, sawTx}, 16'h0041);
    wr16(8'h04, 16'h0000);
    wr16(8'h00, 16'h0042);
    checkEq("R8 no txEvent", {15'h0, sawEvent}, 16'h0000);
    checkEq("R8 strobe without enable", {15'h0, sawStrobe}, 16'h0001);
    wr16(8'h04, 16'h0001);
    rxValid = 1'b1; #1;
    checkEq("R9 rxEvent high", {15'h0, rxEvent}, 16'h0001);
    rxValid = 1'b0; #1;
    checkEq("R9 rxEvent low no data", {15'h0, rxEvent}, 16'h0000);
    wr16(8'h04, 16'h0000);
    rxValid = 1'b1; #1;
    checkEq("R9 rxEvent low no enable", {15'h0, rxEvent}, 16'h0000);
    rxValid = 1'b0;
  endtask

  task automatic testErrors;
    wr16(8'h1C, 16'hBEEF);
    access(1'b1, 8'h1C, 2'd0, 16'h0000);
    checkEq("R10 byte write code", {14'h0, code}, 16'h0001);
    rd16(8'h1C); checkEq("R10 SCR unchanged", rd, 16'hBEEF);
    access(1'b1, 8'h00, 2'd2, 16'h00FF);
    checkEq("R10 word write code", {14'h0, code}, 16'h0001);
    checkEq("R10 no tx strobe", {15'h0, sawStrobe}, 16'h0000);
    access(1'b0, 8'h20, 2'd0, 16'h0);
    checkEq("R10 width before address", {14'h0, code}, 16'h0001);
    checkEq("R12 error data zero", rd, 16'h0000);
    rd16(8'h20); checkEq("R11 hole 0x20", {14'h0, code}, 16'h0002);
    rd16(8'h18); checkEq("R11 hole 0x18", {14'h0, code}, 16'h0002);
    wr16(8'h28, 16'h1111); checkEq("R11 past end", {14'h0, code}, 16'h0002);
    wr16(8'h1E, 16'h2222); checkEq("R11 misaligned", {14'h0, code}, 16'h0002);
    rd16(8'h1C); checkEq("R11 SCR unchanged", rd, 16'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDivisorBank();
    testStorage();
    testIgnored();
    testLiveStatus();
    testReceive();
    testLoopback();
    testEvents();
    testErrors();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule